// File: doc/BRIEF.md
# Stream Level-Crossing Trigger Gate

This block is the last stage of a two-channel sample pipeline, placed directly in front of a DMA engine. Each beat of its input stream is a 32-bit word that carries two 16-bit signed samples. The upper half of the word is channel 1 and the lower half is channel 2. Each sample is a 14-bit value aligned to the top of its 16-bit field, so the two lowest bits are zero. The block is started after every upstream stage is running. Once started, it consumes and discards beats until a trigger condition occurs. It then passes a fixed-length burst to the DMA side, marks the final beat with TLAST, and returns to idle.

There are five trigger sources: a manual request, and a rising or a falling crossing of a programmable level on each channel. Each source has its own enable bit. The enable mask, the two levels and the burst length are sampled when start is accepted. After that, they stay frozen until the block is idle again.

Top module: `stream_trigger_gate`

## Requirements
- R1: After reset, `idle` is 1, `s_tready` is 0 and `m_tvalid` is 0.
- R2: While idle, the block holds `s_tready` low and never asserts `m_tvalid`. A `start` pulse while idle makes `idle` read 0 on the next cycle.
- R3: While armed, a beat that does not trigger is accepted (`s_tready` is 1) and discarded: it never appears on the output.
- R4: Channel 1 is `s_tdata[31:16]` and channel 2 is `s_tdata[15:0]`. Each level is compared as a full 16-bit two's-complement value, so a sample of 0x0100 is above a level of 0xFF00.
- R5: A rising crossing on a channel occurs on a beat whose sample is greater than or equal to the level while the previous accepted sample was below it. A sample landing exactly on the level counts.
- R6: A falling crossing occurs on a beat whose sample is less than or equal to the level while the previous accepted sample was above it.
- R7: In the enable mask, bit 0 is manual, bit 1 is channel 1 rising, bit 2 is channel 1 falling, bit 3 is channel 2 rising and bit 4 is channel 2 falling. A source whose bit is clear never triggers, and this includes the manual request.
- R8: A `manual_trig` pulse while armed with bit 0 set makes the next accepted beat the triggering beat. A pulse while idle has no effect.
- R9: The first beat accepted after `start` only seeds the previous-sample state and cannot produce a crossing.
- R10: The triggering beat is the first of N forwarded beats, where N is the latched burst length (a value of 0 behaves as 1). The Nth beat carries `m_tlast`, and `idle` reads 1 on the cycle after that beat is handed over.
- R11: From the triggering beat onward, `s_tready` follows `m_tready`, and the beat data passes to `m_tdata` unchanged.
- R12: The mask, levels and length are latched when `start` is accepted. Changes to them, and further `start` pulses, while not idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trig_en | input | 5 | Trigger source enable mask |
| cfg_levels | input | 32 | Levels: channel 1 in [31:16], channel 2 in [15:0] |
| cfg_post_len | input | 16 | Number of beats in the burst |
| start | input | 1 | Arms the block when it is idle |
| manual_trig | input | 1 | Manual trigger request pulse |
| idle | output | 1 | High when not armed and not forwarding |
| s_tdata | input | 32 | Input sample word |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | 32 | Output sample word |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Marks the last beat of the burst |

## Verification
Two sources can fire in the same cycle: a pending manual request and a level crossing on the same beat. The bench provokes this by pulsing `manual_trig` while the output is back-pressured, then sending a beat that is also a channel 1 rising crossing. It then judges that only one burst of the latched length follows, with TLAST on the right beat and no duplicated leading beat. A second collision happens when a burst ends and the block goes idle: the bench checks that `s_tready` drops on the cycle after the last beat and that a beat offered then is neither accepted nor forwarded.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;

   typedef enum logic [1:0] {
      GS_IDLE  = 2'd0,
      GS_ARMED = 2'd1,
      GS_RUN   = 2'd2
   } gate_state_e;

   localparam int SRC_MANUAL = 0;

   function automatic int rise_bit(input int ch);
      return 1 + 2 * ch;
   endfunction

   function automatic int fall_bit(input int ch);
      return 2 + 2 * ch;
   endfunction

endpackage

// File: rtl/trig_cfg_latch.sv
module trig_cfg_latch #(
   parameter int EN_W   = 5,
   parameter int LVL_W  = 32,
   parameter int LEN_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             busy,
   input  logic [EN_W-1:0]  cfg_en,
   input  logic [LVL_W-1:0] cfg_levels,
   input  logic [LEN_W-1:0] cfg_len,
   output logic [EN_W-1:0]  en_q,
   output logic [LVL_W-1:0] levels_q,
   output logic [LEN_W-1:0] len_q
);

   logic [LEN_W-1:0] len_eff;

   // a zero length is promoted to a single beat
   always_comb begin
      len_eff = cfg_len;
      if (cfg_len == '0) len_eff = LEN_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         levels_q <= '0;
         len_q    <= LEN_W'(1);
      end else if (load) begin
         en_q     <= cfg_en;
         levels_q <= cfg_levels;
         len_q    <= len_eff;
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(en_q) && $stable(levels_q) && $stable(len_q))); // R12

   AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (len_q != '0)); // R10

endmodule

// File: rtl/trig_cross_detect.sv
module trig_cross_detect #(
   parameter int SMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             adv,
   input  logic [SMP_W-1:0] sample,
   input  logic [SMP_W-1:0] level,
   output logic             rise,
   output logic             fall
);

   logic [SMP_W-1:0] prev_q;
   logic             seeded_q;
   logic             cur_ge, cur_le, prv_lt, prv_gt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= '0;
         seeded_q <= 1'b0;
      end else if (clear) begin
         seeded_q <= 1'b0;
      end else if (adv) begin
         prev_q   <= sample;
         seeded_q <= 1'b1;
      end
   end

   always_comb begin
      cur_ge = $signed(sample) >= $signed(level);
      cur_le = $signed(sample) <= $signed(level);
      prv_lt = $signed(prev_q) <  $signed(level);
      prv_gt = $signed(prev_q) >  $signed(level);
      rise   = seeded_q && cur_ge && prv_lt;
      fall   = seeded_q && cur_le && prv_gt;
   end

   AST_RISE_FALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall)); // R6

   AST_SEED_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !rise && !fall); // R9

endmodule

// File: rtl/trig_burst_count.sv
module trig_burst_count #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             busy,
   input  logic [LEN_W-1:0] len,
   output logic             last
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + LEN_W'(1);
   end

   always_comb last = ((cnt_q + LEN_W'(1)) == len);

   AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q < len)); // R10

endmodule

// File: rtl/stream_trigger_gate.sv
module stream_trigger_gate
   import trig_gate_pkg::*;
#(
   parameter int N_CH  = 2,
   parameter int SMP_W = 16,
   parameter int LEN_W = 16,
   localparam int DATA_W = N_CH * SMP_W,
   localparam int EN_W   = 1 + 2 * N_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EN_W-1:0]   cfg_trig_en,
   input  logic [DATA_W-1:0] cfg_levels,
   input  logic [LEN_W-1:0]  cfg_post_len,
   input  logic              start,
   input  logic              manual_trig,
   output logic              idle,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic              s_tvalid,
   output logic              s_tready,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic              m_tlast
);

   if (N_CH < 1) begin : g_bad_ch
      $error("stream_trigger_gate: N_CH must be at least 1");
   end
   if (SMP_W < 2) begin : g_bad_smp
      $error("stream_trigger_gate: SMP_W must be at least 2");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("stream_trigger_gate: LEN_W must be at least 1");
   end

   gate_state_e       state_q, state_d;
   logic [EN_W-1:0]   en_q;
   logic [DATA_W-1:0] levels_q;
   logic [LEN_W-1:0]  len_q;
   logic              load, armed, running, busy;
   logic              man_pend_q;
   logic              adv, hit, fwd, last_beat;
   logic [EN_W-1:0]   src_vec;
   logic [N_CH-1:0]   rise_v, fall_v;

   always_comb begin
      armed   = (state_q == GS_ARMED);
      running = (state_q == GS_RUN);
      busy    = armed || running;
      idle    = (state_q == GS_IDLE);
      load    = idle && start;
   end

   trig_cfg_latch #(
      .EN_W  (EN_W),
      .LVL_W (DATA_W),
      .LEN_W (LEN_W)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .busy       (busy),
      .cfg_en     (cfg_trig_en),
      .cfg_levels (cfg_levels),
      .cfg_len    (cfg_post_len),
      .en_q       (en_q),
      .levels_q   (levels_q),
      .len_q      (len_q)
   );

   // channel 0 (first channel) occupies the top field of the word
   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam int HI = DATA_W - 1 - c * SMP_W;
      trig_cross_detect #(
         .SMP_W (SMP_W)
      ) u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .clear  (load),
         .adv    (adv),
         .sample (s_tdata[HI -: SMP_W]),
         .level  (levels_q[HI -: SMP_W]),
         .rise   (rise_v[c]),
         .fall   (fall_v[c])
      );
      assign src_vec[rise_bit(c)] = rise_v[c];
      assign src_vec[fall_bit(c)] = fall_v[c];
   end

   assign src_vec[SRC_MANUAL] = man_pend_q;

   // manual request waits for the next accepted beat
   always_ff @(posedge clk) begin
      if (!rst_n)                              man_pend_q <= 1'b0;
      else if (!armed)                         man_pend_q <= 1'b0;
      else if (manual_trig && en_q[SRC_MANUAL]) man_pend_q <= 1'b1;
   end

   always_comb begin
      hit = armed && s_tvalid && (|(src_vec & en_q));
      if (armed)        s_tready = hit ? m_tready : 1'b1;
      else if (running) s_tready = m_tready;
      else              s_tready = 1'b0;
      m_tvalid = hit || (running && s_tvalid);
      m_tdata  = s_tdata;
      adv      = armed && s_tvalid && s_tready;
      fwd      = m_tvalid && m_tready;
   end

   trig_burst_count #(
      .LEN_W (LEN_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load),
      .step  (fwd),
      .busy  (busy),
      .len   (len_q),
      .last  (last_beat)
   );

   always_comb m_tlast = m_tvalid && last_beat;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         GS_IDLE:  if (start) state_d = GS_ARMED;
         GS_ARMED: if (fwd)   state_d = last_beat ? GS_IDLE : GS_RUN;
         GS_RUN:   if (fwd && last_beat) state_d = GS_IDLE;
         default:  state_d = GS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= GS_IDLE;
      else        state_q <= state_d;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!m_tvalid && !s_tready)); // R2

   AST_ARMED_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && s_tvalid && !m_tvalid) |-> s_tready); // R3

   AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tready && m_tlast) |=> idle); // R10

   AST_MANUAL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !en_q[SRC_MANUAL]) |-> !man_pend_q); // R7

   AST_BP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !m_tready) |-> !s_tready); // R11

endmodule

// File: tb/stream_trigger_gate_tb_top.sv
module stream_trigger_gate_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg_trig_en = '0;
   logic [31:0] cfg_levels = '0;
   logic [15:0] cfg_post_len = '0;
   logic        start = 1'b0;
   logic        manual_trig = 1'b0;
   logic        idle;
   logic [31:0] s_tdata = '0;
   logic        s_tvalid = 1'b0;
   logic        s_tready;
   logic [31:0] m_tdata;
   logic        m_tvalid;
   logic        m_tready = 1'b1;
   logic        m_tlast;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit bp_on  = 1'b0;
   string cur_req = "R1";
   logic [32:0] exp_q[$];

   always #2 clk = ~clk;

   stream_trigger_gate dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_trig_en  (cfg_trig_en),
      .cfg_levels   (cfg_levels),
      .cfg_post_len (cfg_post_len),
      .start        (start),
      .manual_trig  (manual_trig),
      .idle         (idle),
      .s_tdata      (s_tdata),
      .s_tvalid     (s_tvalid),
      .s_tready     (s_tready),
      .m_tdata      (m_tdata),
      .m_tvalid     (m_tvalid),
      .m_tready     (m_tready),
      .m_tlast      (m_tlast)
   );

   // downstream ready pattern
   always @(negedge clk) begin
      cyc++;
      m_tready <= bp_on ? ((cyc % 3) != 0) : 1'b1;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      #1;
      if (rst_n && m_tvalid && m_tready) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected beat act=%h last=%0d exp=none", cur_req, m_tdata, m_tlast);
         end else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            if ({m_tlast, m_tdata} !== e) begin
               fails++;
               $display("FAIL %s beat act=%h/%0d exp=%h/%0d", cur_req, m_tdata, m_tlast, e[31:0], e[32]);
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] d, input bit fwd, input bit last);
      if (fwd) exp_q.push_back({last, d});
      s_tdata  = d;
      s_tvalid = 1'b1;
      #1;
      while (!s_tready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      s_tvalid = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_manual();
      manual_trig = 1'b1;
      @(negedge clk);
      manual_trig = 1'b0;
   endtask

   task automatic finish_burst(input string req);
      chk(req, 32'(exp_q.size()), 32'd0);
      chk(req, 32'(idle), 32'd1);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      cur_req = "R1";
      chk("R1 idle", 32'(idle), 32'd1);
      chk("R1 s_tready", 32'(s_tready), 32'd0);
      chk("R1 m_tvalid", 32'(m_tvalid), 32'd0);
      @(negedge clk);

      // rising crossing, equal-to-level, first beat seeded
      cur_req = "R5 R9 R10";
      cfg_trig_en = 5'b00010; cfg_levels = {16'h1000, 16'h0000}; cfg_post_len = 16'd3;
      pulse_start();
      #1;
      chk("R2 idle after start", 32'(idle), 32'd0);
      chk("R3 ready armed", 32'(s_tready), 32'd1);
      @(negedge clk);
      send({16'h2000, 16'h0000}, 0, 0);   // R9 above level on first beat
      send({16'h0800, 16'h0000}, 0, 0);   // R3 discarded
      send({16'h1000, 16'h7FFC}, 1, 0);   // R5 lands on level
      send({16'h1004, 16'h0010}, 1, 0);
      send({16'h0000, 16'h0020}, 1, 1);   // R10 last of three
      finish_burst("R10");
      s_tdata = 32'hDEAD_BEEC; s_tvalid = 1'b1;
      #1;
      chk("R2 ready while idle", 32'(s_tready), 32'd0);
      chk("R2 no output while idle", 32'(m_tvalid), 32'd0);
      @(negedge clk);
      s_tvalid = 1'b0;

      // falling on channel 2 with signed trap; channel 1 fall masked
      cur_req = "R4 R6 R7";
      cfg_trig_en = 5'b10000; cfg_levels = {16'h0000, 16'hFF00}; cfg_post_len = 16'd2;
      pulse_start();
      send({16'h0100, 16'h0000}, 0, 0);
      send({16'hFF00, 16'hFF80}, 0, 0);   // R7 ch1 fall disabled
      send({16'h0000, 16'h0100}, 0, 0);   // R4 unsigned would fire here
      send({16'h0000, 16'hFE00}, 1, 0);   // R6 signed fall
      send({16'h1234, 16'h5678}, 1, 1);
      finish_burst("R6");

      // only channel 2 rising enabled; manual ignored
      cur_req = "R7 R8";
      cfg_trig_en = 5'b01000; cfg_levels = 32'h0; cfg_post_len = 16'd1;
      pulse_start();
      send({16'hFC00, 16'h0400}, 0, 0);
      send({16'h0400, 16'h0400}, 0, 0);   // R7 ch1 rise disabled
      send({16'hFC00, 16'h0400}, 0, 0);   // R7 ch1 fall disabled
      pulse_manual();                     // R7 manual disabled
      send({16'h0000, 16'h0400}, 0, 0);
      send({16'h0000, 16'hFC00}, 0, 0);   // R7 ch2 fall disabled
      send({16'h0000, 16'h0000}, 1, 1);   // ch2 rise, single beat
      finish_burst("R7");

      // manual in idle ignored, config frozen, manual + crossing together, backpressure
      cur_req = "R8 R11 R12";
      pulse_manual();                     // R8 while idle
      cfg_trig_en = 5'b00011; cfg_levels = {16'h0400, 16'h0000}; cfg_post_len = 16'd4;
      pulse_start();
      bp_on = 1'b1;
      cfg_trig_en = 5'b11110; cfg_post_len = 16'd1; cfg_levels = 32'h0;
      pulse_start();                      // R12 ignored
      send({16'h0000, 16'h0000}, 0, 0);   // R8 idle request did not persist
      send({16'h0000, 16'hFC00}, 0, 0);
      send({16'h0000, 16'h0400}, 0, 0);   // R12 new mask would fire here
      pulse_manual();
      send({16'h0400, 16'h0400}, 1, 0);   // R8 manual and ch1 rise together
      send({16'h0800, 16'h0004}, 1, 0);   // R11 under backpressure
      send({16'h0C00, 16'h0008}, 1, 0);
      send({16'h1000, 16'h000C}, 1, 1);   // R12 latched length 4
      finish_burst("R12");
      bp_on = 1'b0;
      @(negedge clk);

      // zero length behaves as one beat
      cur_req = "R10 R8";
      cfg_trig_en = 5'b00001; cfg_levels = 32'h0; cfg_post_len = 16'd0;
      pulse_start();
      send({16'h1234, 16'h5678}, 0, 0);
      pulse_manual();
      send({16'hABCC, 16'h0004}, 1, 1);
      finish_burst("R10");

      repeat (2) @(negedge clk);
      report();
   end

endmodule